// File: doc/BRIEF.md
# Oversampled Serial Receiver with Vote-Based Bit Recovery

This block is the receive half of an asynchronous serial port. A 16x oversampling clock enable, made elsewhere, paces it. The serial line first passes through a short synchronizer. The receiver then waits for the line to go low. From that point it counts sixteen enables per bit. It decides each bit, the start bit included, by a two-of-three vote over the samples taken on the 7th, 8th and 9th enable of that bit. A single-enable disturbance therefore cannot flip a bit, and a short low spike on an idle line cannot start a frame.

Characters are 7 or 8 data bits long, least significant bit first. An optional even or odd parity bit follows the data, then one stop bit. The data bits fill an 8-bit shift register starting at bit 0. With 7 data bits, the parity bit takes bit 7 of the byte. With 8 data bits, it is reported on a separate flag. When the stop bit has been voted, the frame moves into a hold stage. There the parity is checked, and on the next cycle the byte leaves toward the receive FIFO with a one-cycle strobe and its error flags. If the stop bit votes low, the receiver reports a framing error. It then ignores the line until the line has returned high.

Top module: `uart_rx_vote`

## Requirements
- R1: Every bit, the start bit included, lasts exactly 16 enables of `os_tick`. Two frames sent back to back, with the second start bit directly after the first stop bit, are both received correctly.
- R2: Each bit value is the majority of the line samples taken on the 7th, 8th and 9th enable of its bit period. A line inverted for one enable inside that window leaves the bit unchanged.
- R3: A low pulse on the idle line that does not win the start-bit vote produces no output strobe. The next proper frame is received correctly.
- R4: The first data bit received appears in `rx_data[0]`, and later data bits fill the higher positions in order.
- R5: With `cfg_len8`=0 and parity enabled, the received parity bit appears in `rx_data[7]`.
- R6: With `cfg_len8`=1 and parity enabled, all 8 data bits appear in `rx_data`, and the received parity bit appears on `rx_parbit`.
- R7: The `cfg_parity` encoding is 0 for none, 1 for even and 2 for odd; 3 behaves as none. With even or odd parity, `rx_perr` is 1 when the received parity bit does not match the parity computed over the data bits.
- R8: With parity disabled, `rx_perr` and `rx_parbit` are 0. With 7 data bits, `rx_data[7]` is also 0.
- R9: A stop bit that votes 0 still delivers the byte, with `rx_ferr`=1. No further frame starts until the line has been high on an enable. A well-formed frame reports `rx_ferr`=0.
- R10: `rx_valid` is high for exactly one clock cycle per received frame.
- R11: After reset, `rx_valid`, `rx_data`, `rx_parbit`, `rx_perr` and `rx_ferr` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits (static) |
| cfg_parity | input | 2 | 0 none, 1 even, 2 odd, 3 none (static) |
| rx_data | output | 8 | Received character |
| rx_parbit | output | 1 | Received parity bit in 8-bit mode with parity |
| rx_perr | output | 1 | Parity mismatch for this character |
| rx_ferr | output | 1 | Stop bit voted low for this character |
| rx_valid | output | 1 | One-cycle strobe marking a new character |

## Verification
The parity check and the stop-bit check are independent, yet both judge the same frame. Their flags can therefore rise together on a single `rx_valid` strobe. The bench provokes this with an 8-bit even-parity frame that carries a deliberately wrong parity bit and a low stop bit, followed by a held-low line. It expects one strobe with both `rx_perr` and `rx_ferr` set and the data intact. It then expects no further strobe until the line goes high and a clean frame follows, which must report both flags clear.

// File: rtl/uart_rx_vote_pkg.sv
package uart_rx_vote_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_RSVD = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PAR    = 3'd3,
        ST_STOP   = 3'd4,
        ST_WAITHI = 3'd5
    } rx_state_e;

    function automatic logic parity_on(input logic [1:0] mode);
        return (mode == PAR_EVEN) || (mode == PAR_ODD);
    endfunction

endpackage

// File: rtl/rx_sample_voter.sv
module rx_sample_voter #(
    parameter int VOTES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_en,
    input  logic clear,
    input  logic line,
    output logic vote
);
    localparam int NEED = VOTES / 2 + 1;

    logic [VOTES-1:0] smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        if (clear) begin
            smp_d = '0;
        end else if (samp_en) begin
            smp_d = {smp_q[VOTES-2:0], line};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign vote = ($countones(smp_q) >= NEED);

endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import uart_rx_vote_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int VOTES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic       cfg_len8,
    input  logic [1:0] cfg_parity,
    input  logic       vote,
    output logic       samp_en,
    output logic       vclr,
    output logic       fr_ld,
    output logic [7:0] fr_data,
    output logic       fr_par,
    output logic       fr_ferr
);
    localparam int CNT_W  = $clog2(OSR);
    localparam int SMP_LO = OSR / 2 - VOTES / 2;
    localparam int SMP_HI = OSR / 2 + VOTES / 2;
    localparam logic [CNT_W:0] LO_C  = (CNT_W + 1)'(SMP_LO);
    localparam logic [CNT_W:0] HI_C  = (CNT_W + 1)'(SMP_HI);
    localparam logic [CNT_W:0] END_C = (CNT_W + 1)'(OSR);

    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       idx;
        logic [7:0]       sh;
        logic             par;
        logic             ld;
        logic             ferr;
    } fr_s;

    fr_s r_d, r_q;
    logic [CNT_W:0] nxt;
    logic [2:0]     last_idx;

    always_comb begin
        r_d      = r_q;
        r_d.ld   = 1'b0;
        samp_en  = 1'b0;
        vclr     = 1'b0;
        nxt      = {1'b0, r_q.cnt} + 1'b1;
        last_idx = cfg_len8 ? 3'd7 : 3'd6;
        case (r_q.st)
            ST_IDLE: begin
                vclr = 1'b1;
                if (tick && !line) begin
                    r_d.st  = ST_START;
                    r_d.cnt = CNT_W'(1);
                    r_d.idx = '0;
                    r_d.sh  = '0;
                    r_d.par = 1'b0;
                end
            end
            ST_WAITHI: begin
                vclr = 1'b1;
                if (tick && line) r_d.st = ST_IDLE;
            end
            default: begin
                if (tick) begin
                    samp_en = (nxt >= LO_C) && (nxt <= HI_C);
                    if (nxt == END_C) begin
                        r_d.cnt = '0;
                        vclr    = 1'b1;
                        case (r_q.st)
                            ST_START: begin
                                r_d.st = vote ? ST_IDLE : ST_DATA;
                            end
                            ST_DATA: begin
                                r_d.sh[r_q.idx] = vote;
                                if (r_q.idx == last_idx) begin
                                    r_d.st = parity_on(cfg_parity) ? ST_PAR : ST_STOP;
                                end else begin
                                    r_d.idx = r_q.idx + 3'd1;
                                end
                            end
                            ST_PAR: begin
                                if (!cfg_len8) r_d.sh[7] = vote;
                                r_d.par = vote;
                                r_d.st  = ST_STOP;
                            end
                            default: begin
                                r_d.ld   = 1'b1;
                                r_d.ferr = !vote;
                                r_d.st   = vote ? ST_IDLE : ST_WAITHI;
                            end
                        endcase
                    end else begin
                        r_d.cnt = nxt[CNT_W-1:0];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign fr_ld   = r_q.ld;
    assign fr_data = r_q.sh;
    assign fr_par  = r_q.par;
    assign fr_ferr = r_q.ferr;

    // R1: the bit counter moves only on an oversampling enable
    a_r1_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(r_q.cnt));

    // R9: a low line after a framing error never restarts a frame
    a_r9_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAITHI && !line) |=> (r_q.st != ST_START));

    // R10: a frame is handed over only after the stop bit was in progress
    a_r10_load_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        fr_ld |-> ($past(r_q.st) == ST_STOP));

    // R2: sampling and voter clearing never coincide
    a_r2_sample_vs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_en && vclr));

endmodule

// File: rtl/rx_holdbuf.sv
module rx_holdbuf
    import uart_rx_vote_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld,
    input  logic [7:0] in_data,
    input  logic       in_par,
    input  logic       in_ferr,
    input  logic       cfg_len8,
    input  logic [1:0] cfg_parity,
    output logic [7:0] rx_data,
    output logic       rx_parbit,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_valid
);
    typedef struct packed {
        logic       full;
        logic [7:0] bdata;
        logic       bpar;
        logic       bferr;
        logic [7:0] odata;
        logic       opar;
        logic       operr;
        logic       oferr;
        logic       oval;
    } hb_s;

    hb_s h_d, h_q;
    logic par_en;
    logic data_x;
    logic rx_pbit;

    always_comb begin
        h_d      = h_q;
        h_d.oval = 1'b0;
        par_en   = parity_on(cfg_parity);
        data_x   = cfg_len8 ? (^h_q.bdata) : (^h_q.bdata[6:0]);
        rx_pbit  = cfg_len8 ? h_q.bpar : h_q.bdata[7];
        if (h_q.full) begin
            h_d.full  = 1'b0;
            h_d.odata = h_q.bdata;
            h_d.opar  = par_en && cfg_len8 && h_q.bpar;
            h_d.operr = par_en && ((data_x ^ rx_pbit) != (cfg_parity == PAR_ODD));
            h_d.oferr = h_q.bferr;
            h_d.oval  = 1'b1;
        end
        if (ld) begin
            h_d.full  = 1'b1;
            h_d.bdata = in_data;
            h_d.bpar  = in_par;
            h_d.bferr = in_ferr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign rx_data   = h_q.odata;
    assign rx_parbit = h_q.opar;
    assign rx_perr   = h_q.operr;
    assign rx_ferr   = h_q.oferr;
    assign rx_valid  = h_q.oval;

    // R10: the strobe never lasts two cycles
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10: every load is followed by exactly one strobe
    a_r10_load_to_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> ##1 rx_valid);

    // R8: no parity flags when parity is off
    a_r8_nopar_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !parity_on(cfg_parity)) |-> (!rx_perr && !rx_parbit));

    // R8: seven-bit characters without parity have a clear top bit
    a_r8_len7_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_len8 && !parity_on(cfg_parity)) |-> !rx_data[7]);

endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote
    import uart_rx_vote_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int VOTES       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd_i,
    input  logic       cfg_len8,
    input  logic [1:0] cfg_parity,
    output logic [7:0] rx_data,
    output logic       rx_parbit,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_valid
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic       line;
    logic       vote, samp_en, vclr;
    logic       fr_ld, fr_par, fr_ferr;
    logic [7:0] fr_data;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], rxd_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign line = sync_q[SYNC_STAGES-1];

    rx_sample_voter #(.VOTES(VOTES)) u_voter (
        .clk     (clk),
        .rst_n   (rst_n),
        .samp_en (samp_en),
        .clear   (vclr),
        .line    (line),
        .vote    (vote)
    );

    rx_framer #(.OSR(OSR), .VOTES(VOTES)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .line       (line),
        .cfg_len8   (cfg_len8),
        .cfg_parity (cfg_parity),
        .vote       (vote),
        .samp_en    (samp_en),
        .vclr       (vclr),
        .fr_ld      (fr_ld),
        .fr_data    (fr_data),
        .fr_par     (fr_par),
        .fr_ferr    (fr_ferr)
    );

    rx_holdbuf u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld         (fr_ld),
        .in_data    (fr_data),
        .in_par     (fr_par),
        .in_ferr    (fr_ferr),
        .cfg_len8   (cfg_len8),
        .cfg_parity (cfg_parity),
        .rx_data    (rx_data),
        .rx_parbit  (rx_parbit),
        .rx_perr    (rx_perr),
        .rx_ferr    (rx_ferr),
        .rx_valid   (rx_valid)
    );

endmodule

// File: tb/sim_uart_rx_vote.sv
module sim_uart_rx_vote;
    localparam int TPB = 4;          // clocks per oversampling enable
    localparam int BITCLK = 16 * TPB; // clocks per bit

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b0;
    logic rxd = 1'b1;
    logic cfg_len8 = 1'b1;
    logic [1:0] cfg_parity = 2'd0;
    logic [7:0] rx_data;
    logic rx_parbit, rx_perr, rx_ferr, rx_valid;

    int total = 0;
    int bad = 0;
    int vcount = 0;
    int run = 0;
    int maxrun = 0;
    bit finished = 0;
    logic [7:0] cap_data [16];
    logic       cap_par  [16];
    logic       cap_perr [16];
    logic       cap_ferr [16];

    always #5 clk = ~clk;

    uart_rx_vote u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd_i(rxd),
        .cfg_len8(cfg_len8), .cfg_parity(cfg_parity),
        .rx_data(rx_data), .rx_parbit(rx_parbit), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_valid(rx_valid)
    );

    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            os_tick = (k == TPB - 1);
            k = (k + 1) % TPB;
        end
    end

    always @(negedge clk) begin
        if (rx_valid) begin
            cap_data[vcount % 16] = rx_data;
            cap_par[vcount % 16]  = rx_parbit;
            cap_perr[vcount % 16] = rx_perr;
            cap_ferr[vcount % 16] = rx_ferr;
            vcount = vcount + 1;
            run = run + 1;
            if (run > maxrun) maxrun = run;
        end else begin
            run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic l8, input logic [1:0] pm,
                              input logic flip, input logic stopv, input int gbit,
                              input int tail);
        logic p;
        int nd;
        nd = l8 ? 8 : 7;
        p = (l8 ? ^d : ^d[6:0]) ^ (pm == 2'd2) ^ flip;
        hold(1'b0, BITCLK);
        for (int i = 0; i < nd; i++) begin
            if (i == gbit) begin
                hold(d[i], 28);
                hold(~d[i], TPB);
                hold(d[i], BITCLK - 28 - TPB);
            end else begin
                hold(d[i], BITCLK);
            end
        end
        if (pm == 2'd1 || pm == 2'd2) hold(p, BITCLK);
        hold(stopv, BITCLK);
        if (tail > 0) hold(1'b1, tail);
    endtask

    task automatic wait_count(input int target);
        int n = 0;
        while (vcount < target && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic exp_frame(input int idx, input logic [7:0] d, input logic l8,
                             input logic [1:0] pm, input logic flip, input logic stopv,
                             input string req);
        logic p, pon;
        logic [7:0] ed;
        pon = (pm == 2'd1) || (pm == 2'd2);
        p = (l8 ? ^d : ^d[6:0]) ^ (pm == 2'd2) ^ flip;
        ed = l8 ? d : {pon ? p : 1'b0, d[6:0]};
        chk(vcount > idx, {req, " strobe"}, vcount, idx + 1);
        chk(cap_data[idx % 16] == ed, {req, " data"}, cap_data[idx % 16], ed);
        chk(cap_par[idx % 16] == (l8 && pon && p), {req, " parbit"}, cap_par[idx % 16], l8 && pon && p);
        chk(cap_perr[idx % 16] == (pon && flip), {req, " perr"}, cap_perr[idx % 16], pon && flip);
        chk(cap_ferr[idx % 16] == !stopv, {req, " ferr"}, cap_ferr[idx % 16], !stopv);
    endtask

    task automatic one_frame(input logic [7:0] d, input logic l8, input logic [1:0] pm,
                             input logic flip, input int gbit, input string req);
        int v0 = vcount;
        cfg_len8 = l8;
        cfg_parity = pm;
        hold(1'b1, BITCLK);
        send_frame(d, l8, pm, flip, 1'b1, gbit, 8);
        wait_count(v0 + 1);
        exp_frame(v0, d, l8, pm, flip, 1'b1, req);
    endtask

    task automatic t_reset();
        chk(rx_valid == 0, "R11 valid", rx_valid, 0);
        chk(rx_data == 0, "R11 data", rx_data, 0);
        chk({rx_parbit, rx_perr, rx_ferr} == 0, "R11 flags", {rx_parbit, rx_perr, rx_ferr}, 0);
    endtask

    task automatic t_lsb_first();
        one_frame(8'h1E, 1'b1, 2'd0, 1'b0, -1, "R4");
        one_frame(8'h81, 1'b1, 2'd3, 1'b0, -1, "R4 R8 mode3");
    endtask

    task automatic t_len7();
        one_frame(8'hD5, 1'b0, 2'd0, 1'b0, -1, "R8 len7 nopar");
        one_frame(8'h31, 1'b0, 2'd1, 1'b0, -1, "R5 even");
        one_frame(8'h31, 1'b0, 2'd2, 1'b0, -1, "R5 odd");
    endtask

    task automatic t_len8_par();
        one_frame(8'h96, 1'b1, 2'd1, 1'b0, -1, "R6 even");
        one_frame(8'h96, 1'b1, 2'd2, 1'b0, -1, "R6 odd");
    endtask

    task automatic t_perr();
        one_frame(8'h4B, 1'b1, 2'd1, 1'b1, -1, "R7 len8 even");
        one_frame(8'h2C, 1'b0, 2'd2, 1'b1, -1, "R7 len7 odd");
    endtask

    task automatic t_glitch_data();
        one_frame(8'h5A, 1'b1, 2'd0, 1'b0, 3, "R2 bit3");
        one_frame(8'hA4, 1'b0, 2'd1, 1'b0, 0, "R2 bit0");
    endtask

    task automatic t_start_glitch();
        int v0 = vcount;
        cfg_len8 = 1'b1;
        cfg_parity = 2'd0;
        hold(1'b1, BITCLK);
        hold(1'b0, TPB);
        hold(1'b1, 3 * BITCLK);
        chk(vcount == v0, "R3 no strobe", vcount, v0);
        one_frame(8'h6D, 1'b1, 2'd0, 1'b0, -1, "R3 after glitch");
    endtask

    task automatic t_back_to_back();
        int v0 = vcount;
        cfg_len8 = 1'b1;
        cfg_parity = 2'd1;
        hold(1'b1, BITCLK);
        send_frame(8'h3A, 1'b1, 2'd1, 1'b0, 1'b1, -1, 0);
        send_frame(8'hC5, 1'b1, 2'd1, 1'b0, 1'b1, -1, 8);
        wait_count(v0 + 2);
        exp_frame(v0, 8'h3A, 1'b1, 2'd1, 1'b0, 1'b1, "R1 first");
        exp_frame(v0 + 1, 8'hC5, 1'b1, 2'd1, 1'b0, 1'b1, "R1 second");
    endtask

    task automatic t_ferr();
        int v0 = vcount;
        cfg_len8 = 1'b1;
        cfg_parity = 2'd1;
        hold(1'b1, BITCLK);
        send_frame(8'hC3, 1'b1, 2'd1, 1'b1, 1'b0, -1, 0);
        hold(1'b0, 4 * BITCLK);
        wait_count(v0 + 1);
        exp_frame(v0, 8'hC3, 1'b1, 2'd1, 1'b1, 1'b0, "R9 R7 both flags");
        chk(vcount == v0 + 1, "R9 held low no restart", vcount, v0 + 1);
        one_frame(8'h17, 1'b1, 2'd1, 1'b0, -1, "R9 recovery");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_lsb_first();
        t_len7();
        t_len8_par();
        t_perr();
        t_glitch_data();
        t_start_glitch();
        t_back_to_back();
        t_ferr();
        chk(maxrun == 1, "R10 strobe width", maxrun, 1);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule